// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Engine

This block is the read side of a NOR-style memory that can answer either in a simple asynchronous page fashion or as a clocked burst. A 16-bit read configuration word, loaded through a single strobe, chooses between the two. In burst mode the same word also sets:

- the initial latency in clocks;
- the active level of the WAIT output, and whether WAIT clears together with the first valid word or one data cycle ahead of it;
- whether each word is held for one clock or for two;
- whether outputs change on the rising or the falling clock edge.

When chip enable is high and the address-valid strobe is sampled, the engine captures the start address and counts the latency. It then streams words from a built-in array model at consecutive addresses until chip enable drops. WAIT is held at its active level while the engine waits for data.

Reads can also be directed at the identifier space instead of the array. In burst mode such a read returns the same identifier word on every data cycle. The identifier space is also where the configuration word is read back.

Top module: `burst_read_engine`

## Requirements
- R1: After reset the configuration word is 0xBFC0, and `dout` is 0 and `wait_o` is 0. A write with `cfg_load` high takes effect at that clock edge. The stored word reads back as the identifier word at offset 5.
- R2: On load, bits 14, 5 and 4 are cleared and bit 7 is forced to 1. Bits 3:0 are stored as written and have no other effect.
- R3: A loaded latency code (bits 13:11) of 0 or 1 is stored and used as 7.
- R4: With bit 15 at 1 (asynchronous mode) and `ce` high, `dout` shows the word for the current `addr` one clock later. Array words are `(addr * 257) ^ 0x3C96` truncated to 16 bits. `wait_o` stays at its inactive level, and `adv` has no effect.
- R5: With bit 15 at 0, `ce` and `adv` both high at edge E0 start a burst. `dout` is 0 until edge E0+L, where L is the latency code, and from that edge it carries the first word.
- R6: Array words follow at consecutive addresses, wrapping at the address width. Each word is held for 1 clock when bit 9 is 0 and for 2 clocks when bit 9 is 1. `addr` and `id_sel` are ignored after the start edge.
- R7: WAIT uses bit 10 as its active level (1 means active high) and the inverse as its inactive level. With bit 8 at 0 it is active from edge E0 until edge E0+L and inactive from then on.
- R8: With bit 8 at 1, WAIT turns inactive one data cycle (1 or 2 clocks, as set by bit 9) before the first word. It is never active when that point is at or before E0.
- R9: Identifier reads (`id_sel` high at the start) return 0x0071 at offset 0, 0x88C1 at offset 1, the configuration word at offset 5, and 0 elsewhere. A burst of this kind repeats the same word on every data cycle.
- R10: With bit 6 at 1, `dout` and `wait_o` change just after the rising edge. With bit 6 at 0, the same sequence appears half a clock later, at the falling edge.
- R11: `ce` low at an edge makes the engine idle, with `dout` 0 and WAIT inactive. `adv` during a burst restarts latency counting from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration value to load |
| ce | input | 1 | Chip enable, active high |
| adv | input | 1 | Address-valid strobe, active high |
| addr | input | AW | Word address, or identifier offset |
| id_sel | input | 1 | Selects the identifier space instead of the array |
| dout | output | 16 | Read data |
| wait_o | output | 1 | WAIT indication, polarity set by bit 10 |

## Verification
The bench uses the default build: an 8-bit address, two identifier entries and the configuration word at offset 5. With only 256 addresses, a burst that crosses the top of the array and wraps fits in a few clocks. Latency codes, hold lengths, lead settings and WAIT polarities together give just 48 burst configurations, so the bench sweeps every one of them and checks each cycle against arithmetic expectations. Falling-edge timing, reserved-code fix-ups, restarts and identifier repetition are each covered by dedicated runs.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'hBFC0;

  typedef struct packed {
    logic       rm;      // 1: asynchronous page mode
    logic       rsv14;
    logic [2:0] lat;     // latency code
    logic       wpol;    // WAIT active level
    logic       hold2;   // two-clock data cycles
    logic       lead;    // WAIT clears one data cycle early
    logic       lin;     // linear sequence (always 1)
    logic       rise;    // rising-edge outputs
    logic [1:0] rsv54;
    logic [3:0] low;     // stored, no effect here
  } cfg_t;

  typedef enum logic [1:0] {S_IDLE, S_LAT, S_DATA} seq_state_e;

  function automatic cfg_t cfg_clean(input logic [CFG_W-1:0] raw);
    cfg_t c;
    c       = cfg_t'(raw);
    c.rsv14 = 1'b0;
    c.rsv54 = 2'b00;
    c.lin   = 1'b1;
    if (c.lat < 3'd2) c.lat = 3'd7;
    return c;
  endfunction
endpackage

// File: rtl/brd_cfg_reg.sv
module brd_cfg_reg
  import brd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= cfg_t'(CFG_RESET);
    else if (load) cfg_q <= cfg_clean(wdata);
  end
endmodule

// File: rtl/brd_word_src.sv
module brd_word_src #(
  parameter int              AW       = 8,
  parameter int              DW       = 16,
  parameter logic [DW-1:0]   SEED     = 16'h3C96,
  parameter logic [DW-1:0]   MIX      = 16'd257,
  parameter int              N_ID     = 2,
  parameter logic [N_ID*DW-1:0] ID_TABLE = {16'h88C1, 16'h0071},
  parameter int              CFG_OFF  = 5
) (
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_id,
  input  logic [DW-1:0] cfg_word,
  output logic [DW-1:0] word
);
  logic [DW-1:0] arr_word;
  logic [DW-1:0] id_word;
  logic [DW-1:0] hit_word [N_ID];

  genvar g;
  generate
    for (g = 0; g < N_ID; g++) begin : g_id
      assign hit_word[g] = (rd_addr == AW'(g)) ? ID_TABLE[g*DW +: DW] : '0;
    end
  endgenerate

  always_comb begin
    arr_word = (DW'(rd_addr) * MIX) ^ SEED;
    id_word  = (rd_addr == AW'(CFG_OFF)) ? cfg_word : '0;
    for (int i = 0; i < N_ID; i++) id_word = id_word | hit_word[i];
    word = rd_id ? id_word : arr_word;
  end
endmodule

// File: rtl/brd_burst_seq.sv
module brd_burst_seq
  import brd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          adv,
  input  logic [AW-1:0] addr,
  input  logic          id_sel,
  input  logic          rm,
  input  logic [2:0]    lat,
  input  logic          wpol,
  input  logic          hold2,
  input  logic          lead,
  input  logic [DW-1:0] word,
  output logic [AW-1:0] rd_addr,
  output logic          rd_id,
  output logic [DW-1:0] dout_q,
  output logic          wait_q,
  output logic          in_data,
  output logic          rep_q
);
  seq_state_e    st;
  logic [3:0]    cnt;
  logic [3:0]    thr_q;
  logic [3:0]    thr_live;
  logic [2:0]    lat_q;
  logic [AW-1:0] ptr;
  logic [AW-1:0] step;
  logic          h2_q;
  logic          ph;

  // WAIT stays active while the phase count is below the threshold
  always_comb begin
    thr_live = {1'b0, lat} - (lead ? (hold2 ? 4'd2 : 4'd1) : 4'd0);
    step     = rep_q ? '0 : AW'(1);
    if (rm) begin
      rd_addr = addr;
      rd_id   = id_sel;
    end else if (st == S_DATA) begin
      rd_addr = ptr + step;
      rd_id   = rep_q;
    end else begin
      rd_addr = ptr;
      rd_id   = rep_q;
    end
  end

  assign in_data = (st == S_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      thr_q  <= '0;
      lat_q  <= 3'd7;
      ptr    <= '0;
      h2_q   <= 1'b1;
      ph     <= 1'b0;
      rep_q  <= 1'b0;
      dout_q <= '0;
      wait_q <= 1'b0;
    end else if (!ce) begin
      st     <= S_IDLE;
      dout_q <= '0;
      wait_q <= ~wpol;
    end else if (rm) begin
      st     <= S_IDLE;
      dout_q <= word;
      wait_q <= ~wpol;
    end else if (adv) begin
      st     <= S_LAT;
      cnt    <= 4'd1;
      thr_q  <= thr_live;
      lat_q  <= lat;
      ptr    <= addr;
      h2_q   <= hold2;
      ph     <= 1'b0;
      rep_q  <= id_sel;
      dout_q <= '0;
      wait_q <= ~((thr_live != 4'd0) ^ wpol);
    end else begin
      case (st)
        S_LAT: begin
          cnt <= cnt + 4'd1;
          if (cnt == {1'b0, lat_q}) begin
            st     <= S_DATA;
            dout_q <= word;
            ph     <= 1'b0;
            wait_q <= ~wpol;
          end else begin
            dout_q <= '0;
            wait_q <= ~((cnt < thr_q) ^ wpol);
          end
        end
        S_DATA: begin
          wait_q <= ~wpol;
          if (!h2_q || ph) begin
            ptr    <= ptr + step;
            dout_q <= word;
            ph     <= 1'b0;
          end else begin
            ph <= 1'b1;
          end
        end
        default: begin
          dout_q <= '0;
          wait_q <= ~wpol;
        end
      endcase
    end
  end
endmodule

// File: rtl/brd_out_stage.sv
module brd_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_sel,
  input  logic [DW-1:0] d_in,
  input  logic          w_in,
  output logic [DW-1:0] d_out,
  output logic          w_out
);
  logic [DW-1:0] d_f;
  logic          w_f;

  // half-clock retimed copy for falling-edge output mode
  always_ff @(negedge clk) begin
    if (rst) begin
      d_f <= '0;
      w_f <= 1'b0;
    end else begin
      d_f <= d_in;
      w_f <= w_in;
    end
  end

  assign d_out = rise_sel ? d_in : d_f;
  assign w_out = rise_sel ? w_in : w_f;
endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
  import brd_pkg::*;
#(
  parameter int                  AW       = 8,
  parameter logic [CFG_W-1:0]    SEED     = 16'h3C96,
  parameter logic [CFG_W-1:0]    MIX      = 16'd257,
  parameter int                  N_ID     = 2,
  parameter logic [N_ID*CFG_W-1:0] ID_TABLE = {16'h88C1, 16'h0071},
  parameter int                  CFG_OFF  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ce,
  input  logic             adv,
  input  logic [AW-1:0]    addr,
  input  logic             id_sel,
  output logic [CFG_W-1:0] dout,
  output logic             wait_o
);
  localparam int DW = CFG_W;

  cfg_t          cfg_q;
  logic [AW-1:0] src_addr;
  logic          src_id;
  logic [DW-1:0] src_word;
  logic [DW-1:0] seq_dout;
  logic          seq_wait;
  logic          seq_in_data;
  logic          seq_rep;

  brd_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .load  (cfg_load),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q)
  );

  brd_word_src #(
    .AW(AW), .DW(DW), .SEED(SEED), .MIX(MIX),
    .N_ID(N_ID), .ID_TABLE(ID_TABLE), .CFG_OFF(CFG_OFF)
  ) u_src (
    .rd_addr  (src_addr),
    .rd_id    (src_id),
    .cfg_word (cfg_q),
    .word     (src_word)
  );

  brd_burst_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .adv     (adv),
    .addr    (addr),
    .id_sel  (id_sel),
    .rm      (cfg_q.rm),
    .lat     (cfg_q.lat),
    .wpol    (cfg_q.wpol),
    .hold2   (cfg_q.hold2),
    .lead    (cfg_q.lead),
    .word    (src_word),
    .rd_addr (src_addr),
    .rd_id   (src_id),
    .dout_q  (seq_dout),
    .wait_q  (seq_wait),
    .in_data (seq_in_data),
    .rep_q   (seq_rep)
  );

  brd_out_stage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .rise_sel (cfg_q.rise),
    .d_in     (seq_dout),
    .w_in     (seq_wait),
    .d_out    (dout),
    .w_out    (wait_o)
  );
endmodule

// File: rtl/brd_checker.sv
module brd_checker (
  input logic        clk,
  input logic        rst,
  input logic        ce,
  input logic [15:0] cfg_word,
  input logic [15:0] dout_lvl,
  input logic        wait_lvl,
  input logic        in_data,
  input logic        rep
);
  assert_rsv_clean_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[14] == 1'b0 && cfg_word[5:4] == 2'b00 && cfg_word[7] == 1'b1));

  assert_lat_legal_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[13:11] >= 3'd2));

  assert_async_nowait_R4: assert property (@(posedge clk) disable iff (rst)
    (ce && cfg_word[15]) |=> (wait_lvl == !$past(cfg_word[10])));

  assert_data_nowait_R7: assert property (@(posedge clk) disable iff (rst)
    in_data |-> (wait_lvl == !$past(cfg_word[10])));

  assert_id_repeat_R9: assert property (@(posedge clk) disable iff (rst)
    (in_data && $past(in_data) && rep && ($past(cfg_word) == $past(cfg_word, 2)))
      |-> $stable(dout_lvl));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!ce) |=> (dout_lvl == 16'h0000 && wait_lvl == !$past(cfg_word[10])));
endmodule

bind burst_read_engine brd_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce       (ce),
  .cfg_word (cfg_q),
  .dout_lvl (seq_dout),
  .wait_lvl (seq_wait),
  .in_data  (seq_in_data),
  .rep      (seq_rep)
);

// File: tb/burst_read_engine_test.sv
module burst_read_engine_test;
  localparam int          AW   = 8;
  localparam logic [15:0] SEED = 16'h3C96;
  localparam logic [15:0] ID0  = 16'h0071;
  localparam logic [15:0] ID1  = 16'h88C1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_load = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic          ce = 1'b0;
  logic          adv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          id_sel = 1'b0;
  logic [15:0]   dout;
  logic          wait_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] model = 16'hBFC0;

  always #5 clk = ~clk;

  burst_read_engine uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_wdata(cfg_wdata),
    .ce(ce), .adv(adv), .addr(addr), .id_sel(id_sel),
    .dout(dout), .wait_o(wait_o)
  );

  function automatic logic [15:0] word_of(input logic [AW-1:0] a);
    return (16'(a) * 16'd257) ^ SEED;
  endfunction

  function automatic logic [15:0] id_word(input logic [AW-1:0] a);
    if (a == 8'd5) return model;
    if (a == 8'd0) return ID0;
    if (a == 8'd1) return ID1;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] clean(input logic [15:0] r);
    logic [15:0] c;
    c = r;
    c[14] = 1'b0;
    c[5:4] = 2'b00;
    c[7] = 1'b1;
    if (c[13:11] < 3'd2) c[13:11] = 3'd7;
    return c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_cfg(input logic [15:0] raw);
    tick();
    ce = 1'b0; adv = 1'b0;
    cfg_load = 1'b1; cfg_wdata = raw;
    tick();
    cfg_load = 1'b0;
    model = clean(raw);
    tick();
    tick();
  endtask

  task automatic async_read(input logic [AW-1:0] a, input logic na, input string tag);
    logic [15:0] e;
    tick();
    ce = 1'b1; adv = 1'b1; addr = a; id_sel = na;
    tick();
    #6;
    e = na ? id_word(a) : word_of(a);
    chk(tag, dout, e);
    chk("R4 async wait inactive", {15'd0, wait_o}, {15'd0, ~model[10]});
  endtask

  task automatic run_burst(input logic [AW-1:0] a, input logic na, input int ncyc,
                           input bit keep, input string dtag);
    int L, h, lead;
    logic wp, rise, ew;
    logic [15:0] ed, prev_ed;
    logic [AW-1:0] ea;
    L = int'(model[13:11]);
    h = model[9] ? 2 : 1;
    lead = model[8] ? h : 0;
    wp = model[10];
    rise = model[6];
    tick();
    ce = 1'b1; adv = 1'b1; addr = a; id_sel = na;
    prev_ed = '0;
    for (int n = 0; n < ncyc; n++) begin
      tick();
      adv = 1'b0; addr = ~a; id_sel = ~na;
      if (n < L) ed = '0;
      else if (na) ed = id_word(a);
      else begin
        ea = a + AW'((n - L) / h);
        ed = word_of(ea);
      end
      ew = (n < L - lead) ? wp : ~wp;
      #1;
      if (n == L) chk("R10 edge select", dout, rise ? ed : prev_ed);
      #5;
      chk((n < L) ? "R5 latency" : dtag, dout, ed);
      chk(model[8] ? "R8 wait lead" : "R7 wait level", {15'd0, wait_o}, {15'd0, ew});
      prev_ed = ed;
    end
    if (!keep) begin
      tick();
      ce = 1'b0;
      tick();
      #6;
      chk("R11 idle data", dout, 16'h0000);
      chk("R11 idle wait", {15'd0, wait_o}, {15'd0, ~wp});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    #6;
    chk("R1 reset dout", dout, 16'h0000);
    chk("R1 reset wait", {15'd0, wait_o}, 16'h0000);

    // identifier space and array reads in asynchronous mode
    async_read(8'd5, 1'b1, "R1 readback reset word");
    async_read(8'd0, 1'b1, "R9 id offset 0");
    async_read(8'd1, 1'b1, "R9 id offset 1");
    async_read(8'd9, 1'b1, "R9 id unused offset");
    for (int i = 0; i < 6; i++) async_read(AW'(i * 51 + 7), 1'b0, "R4 async array");

    // full sweep of burst timing configurations, rising edge
    for (int L = 2; L <= 7; L++)
      for (int dh = 0; dh < 2; dh++)
        for (int wd = 0; wd < 2; wd++)
          for (int wp = 0; wp < 2; wp++) begin
            load_cfg({1'b0, 1'b0, 3'(L), 1'(wp), 1'(dh), 1'(wd), 1'b1, 1'b1, 2'b00, 4'b0000});
            run_burst(AW'(L * 37 + dh * 5 + wd * 3 + wp), 1'b0, L + 10, 1'b0, "R6 linear");
          end

    // wrap across the top of the array
    load_cfg(16'h1640);
    run_burst(8'hFD, 1'b0, 3 + 8, 1'b0, "R6 wrap");

    // falling-edge output timing
    load_cfg(16'h1500);
    run_burst(8'h30, 1'b0, 12, 1'b0, "R10 falling hold1");
    load_cfg(16'h2F00);
    run_burst(8'h44, 1'b0, 14, 1'b0, "R10 falling hold2");

    // identifier bursts repeat one word
    load_cfg(16'h2640);
    run_burst(8'd5, 1'b1, 12, 1'b0, "R9 repeat cfg word");
    run_burst(8'd1, 1'b1, 12, 1'b0, "R9 repeat id1");

    // restart by a new address strobe during a burst
    load_cfg(16'h1C40);
    run_burst(8'h20, 1'b0, 6, 1'b1, "R6 before restart");
    run_burst(8'h60, 1'b0, 9, 1'b0, "R11 restart data");

    // reserved bits and reserved codes
    load_cfg(16'hFFFF);
    async_read(8'd5, 1'b1, "R2 reserved masked");
    chk("R2 model value", model, 16'hBFCF);
    load_cfg(16'h4800);
    run_burst(8'd5, 1'b1, 11, 1'b0, "R3 code 1 readback");
    load_cfg(16'h0640);
    run_burst(8'h10, 1'b0, 12, 1'b0, "R3 code 0 latency");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule